// File: doc/BRIEF.md
# Transmit Data Fetch Engine

This block moves the payload of one selected outgoing CAN message from a buffer in system memory into the transmit data port of the CAN core. A controller gives it a buffer base address, the 4-bit data length code and the remote-frame flag, and pulses `start_i`. The engine then runs one read per byte. For each byte it raises a bus request, waits for the grant, captures the byte one cycle later, and offers it to the core on a valid/ready handshake.

The buffer holds only data bytes. The identifier and frame information come from registers elsewhere, so nothing is fetched for them. Byte 0 sits at the base address and each later byte sits one address higher. When the last byte is accepted, or at once when there is nothing to move, the engine pulses `done_o` for one cycle and returns to idle.

Top module: `txf_fetch_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `busy_o`, `bus_req_o`, `core_valid_o` and `done_o` are all 0.
- R2: The number of bytes read and delivered equals the data length code when it is 1 to 8. Any code from 9 to 15 moves exactly 8 bytes.
- R3: A data length code of 0, or `rtr_i` = 1 with any code, finishes without a bus request or core transfer, and `done_o` is high in the cycle after `start_i` is sampled.
- R4: Byte i is read from address base + i, taken modulo 2^AW. Bytes reach the core in increasing i order and carry the memory value at that address.
- R5: `bus_req_o` stays high, with `mem_addr_o` unchanged, until a cycle in which `bus_grant_i` is high. Each grant reads exactly one byte, and the read data is taken from `mem_rdata_i` one cycle after the grant.
- R6: While `core_valid_o` is high and `core_ready_i` is low, `core_valid_o` stays high in the next cycle and `core_data_o` does not change.
- R7: `done_o` is high for exactly one cycle, in the cycle right after the final byte is accepted by the core.
- R8: `start_i` has no effect while `busy_o` is high. The running message keeps its length and addresses, and only one `done_o` pulse is produced.
- R9: `bus_req_o` and `core_valid_o` are never high in the same cycle, so at most one byte is in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin fetching one message |
| base_addr_i | input | AW | Address of data byte 0 |
| dlc_i | input | 4 | Data length code |
| rtr_i | input | 1 | Remote frame; no payload |
| busy_o | output | 1 | Engine is running a message |
| done_o | output | 1 | One-cycle completion pulse |
| bus_req_o | output | 1 | Memory bus request for one byte read |
| bus_grant_i | input | 1 | Bus grant; the read is taken in this cycle |
| mem_addr_o | output | AW | Read address, valid while requesting |
| mem_rdata_i | input | 8 | Read data, valid one cycle after grant |
| core_valid_o | output | 1 | Byte offered to the CAN core |
| core_ready_i | input | 1 | CAN core accepts the byte |
| core_data_o | output | 8 | Byte to the CAN core |

## Verification
Properties are checked on every cycle for several behaviours. These are the held request with a stable address until grant, the held byte under core back-pressure, the single-cycle done pulse, the rule that requests and valid bytes never overlap, and the immediate finish for empty or remote frames. Only the directed scenarios can show that the right number of bytes arrives for each length code and that the bytes come from the right addresses in order, including the wrap at the top of the address space. The scenarios also show that a start given mid-message is ignored and that completion lands exactly one cycle after the last accepted byte under varied grant and ready stalls.

// File: rtl/txf_pkg.sv
package txf_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_PUSH,
    ST_DONE
  } txf_state_e;

endpackage

// File: rtl/txf_len_calc.sv
module txf_len_calc #(
  parameter int DLCW      = 4,
  parameter int MAX_BYTES = 8,
  parameter int LW        = $clog2(MAX_BYTES + 1)
) (
  input  logic [DLCW-1:0] dlc_i,
  input  logic            rtr_i,
  output logic [LW-1:0]   len_o
);

  localparam int CMPW = (DLCW > LW) ? DLCW : LW;

  logic [CMPW-1:0] dlc_ext;
  logic [CMPW-1:0] max_ext;

  always_comb begin
    dlc_ext = CMPW'(dlc_i);
    max_ext = CMPW'(MAX_BYTES);
    if (rtr_i) begin
      len_o = '0;
    end else if (dlc_ext > max_ext) begin
      len_o = LW'(MAX_BYTES);
    end else begin
      len_o = LW'(dlc_i);
    end
  end

endmodule

// File: rtl/txf_ptr.sv
module txf_ptr #(
  parameter int AW = 16,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [AW-1:0] base_i,
  input  logic [LW-1:0] len_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);

  logic [AW-1:0] addr_q, addr_d;
  logic [LW-1:0] rem_q, rem_d;

  always_comb begin
    addr_d = addr_q;
    rem_d  = rem_q;
    if (load_i) begin
      addr_d = base_i;
      rem_d  = len_i;
    end else if (step_i) begin
      addr_d = addr_q + AW'(1);
      rem_d  = rem_q - LW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rem_q  <= '0;
    end else if (load_i || step_i) begin
      addr_q <= addr_d;
      rem_q  <= rem_d;
    end
  end

  assign addr_o = addr_q;
  assign last_o = (rem_q == LW'(1));

endmodule

// File: rtl/txf_hold.sv
module txf_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] dout_o
);

  logic [DW-1:0] data_q, data_d;

  always_comb begin
    data_d = cap_i ? din_i : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (cap_i) begin
      data_q <= data_d;
    end
  end

  assign dout_o = data_q;

endmodule

// File: rtl/txf_fetch_top.sv
module txf_fetch_top
  import txf_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int DLCW      = 4,
  parameter int MAX_BYTES = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [AW-1:0]   base_addr_i,
  input  logic [DLCW-1:0] dlc_i,
  input  logic            rtr_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            bus_req_o,
  input  logic            bus_grant_i,
  output logic [AW-1:0]   mem_addr_o,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic            core_valid_o,
  input  logic            core_ready_i,
  output logic [DW-1:0]   core_data_o
);

  localparam int LW = $clog2(MAX_BYTES + 1);

  txf_state_e    st_q, st_d;
  logic [LW-1:0] len;
  logic          load, step, cap, last;

  txf_len_calc #(.DLCW(DLCW), .MAX_BYTES(MAX_BYTES), .LW(LW)) u_len (
    .dlc_i (dlc_i),
    .rtr_i (rtr_i),
    .len_o (len)
  );

  txf_ptr #(.AW(AW), .LW(LW)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load),
    .step_i (step),
    .base_i (base_addr_i),
    .len_i  (len),
    .addr_o (mem_addr_o),
    .last_o (last)
  );

  txf_hold #(.DW(DW)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_i  (cap),
    .din_i  (mem_rdata_i),
    .dout_o (core_data_o)
  );

  always_comb begin
    st_d = st_q;
    load = 1'b0;
    step = 1'b0;
    cap  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          load = 1'b1;
          st_d = (len == '0) ? ST_DONE : ST_REQ;
        end
      end
      ST_REQ: begin
        if (bus_grant_i) st_d = ST_WAIT;
      end
      ST_WAIT: begin
        cap  = 1'b1;
        st_d = ST_PUSH;
      end
      ST_PUSH: begin
        if (core_ready_i) begin
          if (last) begin
            st_d = ST_DONE;
          end else begin
            step = 1'b1;
            st_d = ST_REQ;
          end
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign busy_o       = (st_q != ST_IDLE);
  assign bus_req_o    = (st_q == ST_REQ);
  assign core_valid_o = (st_q == ST_PUSH);
  assign done_o       = (st_q == ST_DONE);

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && !bus_grant_i) |=> (bus_req_o && $stable(mem_addr_o)));

  // R6
  byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_valid_o && !core_ready_i) |=> (core_valid_o && $stable(core_data_o)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9
  one_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req_o && core_valid_o));

  // R3
  empty_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && (rtr_i || dlc_i == '0)) |=> (done_o && !bus_req_o));

endmodule

// File: tb/txf_fetch_top_test.sv
`timescale 1ns/100ps
module txf_fetch_top_test;

  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i;
  logic [AW-1:0] base_addr_i;
  logic [3:0]    dlc_i;
  logic          rtr_i;
  logic          busy_o, done_o, bus_req_o, bus_grant_i;
  logic [AW-1:0] mem_addr_o;
  logic [7:0]    mem_rdata_i;
  logic          core_valid_o, core_ready_i;
  logic [7:0]    core_data_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int grant_mode = 0;
  int ready_mode = 0;
  int pat = 0;

  int   nbytes, nreads, ndone, hs_cyc, done_cyc, start_cyc;
  logic [7:0] got [16];
  logic       stall_prev;
  logic [7:0] stall_data;

  txf_fetch_top #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_addr_i(base_addr_i),
    .dlc_i(dlc_i), .rtr_i(rtr_i), .busy_o(busy_o), .done_o(done_o),
    .bus_req_o(bus_req_o), .bus_grant_i(bus_grant_i), .mem_addr_o(mem_addr_o),
    .mem_rdata_i(mem_rdata_i), .core_valid_o(core_valid_o),
    .core_ready_i(core_ready_i), .core_data_o(core_data_o)
  );

  always #2.5 clk = ~clk;

  function automatic logic [7:0] mval(input logic [AW-1:0] a);
    return a[7:0] * 8'd37 + 8'h5A;
  endfunction

  always_ff @(posedge clk) begin
    cyc <= cyc + 1;
    if (bus_req_o && bus_grant_i) mem_rdata_i <= mval(mem_addr_o);
  end

  always begin
    @(posedge clk);
    #1;
    pat = pat + 1;
    bus_grant_i  = (grant_mode == 0) ? 1'b1 : ((pat % 3) == 0);
    core_ready_i = (ready_mode == 0) ? 1'b1 : ((pat % 4) == 1);
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_prev) begin
        n_chk++;
        if (!core_valid_o || core_data_o !== stall_data) begin
          n_bad++;
          $display("FAIL R6 held byte: valid=%0b data=%02h expected valid=1 data=%02h",
                   core_valid_o, core_data_o, stall_data);
        end
      end
      stall_prev = core_valid_o && !core_ready_i;
      stall_data = core_data_o;
      if (start_i && !busy_o) start_cyc = cyc;
      if (bus_req_o && bus_grant_i) nreads++;
      if (core_valid_o && core_ready_i) begin
        if (nbytes < 16) got[nbytes] = core_data_o;
        nbytes++;
        hs_cyc = cyc;
      end
      if (done_o) begin
        ndone++;
        done_cyc = cyc;
      end
    end else begin
      stall_prev = 1'b0;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [AW-1:0] base, input logic [3:0] dlc, input logic rtr);
    @(negedge clk);
    base_addr_i = base; dlc_i = dlc; rtr_i = rtr; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic run_msg(input string req, input logic [AW-1:0] base,
                         input logic [3:0] dlc, input logic rtr, input bit mid_start);
    int exp_n;
    exp_n = rtr ? 0 : ((dlc > 8) ? 8 : int'(dlc));
    nbytes = 0; nreads = 0; ndone = 0; hs_cyc = -1; done_cyc = -1; start_cyc = -1;
    pulse_start(base, dlc, rtr);
    if (mid_start) begin
      repeat (4) @(negedge clk);
      pulse_start(base + 16'd40, 4'd2, 1'b0);
    end
    for (int i = 0; i < 300 && ndone == 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    check({req, " byte count"}, nbytes, exp_n);
    check({req, " read count"}, nreads, exp_n);
    check({req, " done pulses"}, ndone, 1);
    if (exp_n == 0) check({req, " done timing"}, done_cyc, start_cyc + 1);
    else            check({req, " done timing R7"}, done_cyc, hs_cyc + 1);
    for (int i = 0; i < exp_n && i < nbytes; i++)
      check({req, " R4 byte value"}, int'(got[i]), int'(mval(base + AW'(i))));
  endtask

  task automatic t_reset;
    check("R1 busy", int'(busy_o), 0);
    check("R1 req", int'(bus_req_o), 0);
    check("R1 valid", int'(core_valid_o), 0);
    check("R1 done", int'(done_o), 0);
  endtask

  task automatic t_full_fast;   grant_mode = 0; ready_mode = 0; run_msg("R2 dlc8 fast", 16'h0100, 4'd8, 1'b0, 0); endtask
  task automatic t_short_stall; grant_mode = 1; ready_mode = 1; run_msg("R5 dlc3 stalled", 16'h0230, 4'd3, 1'b0, 0); endtask
  task automatic t_big_dlc;     grant_mode = 1; ready_mode = 0; run_msg("R2 dlc13 clamp", 16'h0040, 4'd13, 1'b0, 0); endtask
  task automatic t_zero;        grant_mode = 0; ready_mode = 0; run_msg("R3 dlc0", 16'h0010, 4'd0, 1'b0, 0); endtask
  task automatic t_rtr;         grant_mode = 0; ready_mode = 0; run_msg("R3 rtr", 16'h0010, 4'd5, 1'b1, 0); endtask
  task automatic t_wrap;        grant_mode = 0; ready_mode = 1; run_msg("R4 wrap", 16'hFFFD, 4'd6, 1'b0, 0); endtask
  task automatic t_busy_start;  grant_mode = 1; ready_mode = 1; run_msg("R8 start while busy", 16'h0300, 4'd8, 1'b0, 1); endtask
  task automatic t_one;         grant_mode = 1; ready_mode = 1; run_msg("R9 dlc1", 16'h0077, 4'd1, 1'b0, 0); endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; base_addr_i = '0; dlc_i = '0; rtr_i = 1'b0;
    bus_grant_i = 1'b0; core_ready_i = 1'b0; mem_rdata_i = '0;
    stall_prev = 1'b0; stall_data = '0;
    nbytes = 0; nreads = 0; ndone = 0; hs_cyc = -1; done_cyc = -1; start_cyc = -1;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_full_fast;
    t_short_stall;
    t_big_dlc;
    t_zero;
    t_rtr;
    t_wrap;
    t_busy_start;
    t_one;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule